// File: doc/BRIEF.md
# Virtual Interrupt List-Register Lookup Unit

This block keeps a small bank of list registers for one virtual CPU interface of an interrupt controller. Each 32-bit register describes one virtual interrupt. The block decodes every register at all times and reports two per-entry status vectors. One marks entries that are free for reuse. The other marks entries that are waiting for end-of-interrupt maintenance.

The block answers three lookups by virtual interrupt ID, and each uses its own match rule. Delivery picks the pending entry to present to the guest. Completion checks an end-of-interrupt or deactivate write against an entry whose active bit is set. Re-lookup finds again an entry that is already in use, and flags an error when it finds none. A completion that hits retires the active part of the entry on the next clock edge. A completion that misses advances a wrapping counter and changes no entry.

Software, or a hypervisor model, loads the registers through an indexed write port and reads any register back through an indexed read port.

Top module: `vlr_lookup_unit`

## Requirements
- R1: Register word layout: bits [9:0] virtual ID, [18:10] physical ID, [21:19] source CPU, [22] EOI request, [27:23] stored priority, [28] group, [29] hardware, [31:30] state (0 invalid, 1 pending, 2 active, 3 active-and-pending). A write appears unchanged on `rd_data` from the next cycle. The full priority is the stored field shifted left by 3.
- R2: `empty_vec[i]` is 1 exactly when entry i has state 0 and either its hardware bit is 1 or its EOI-request bit is 0.
- R3: `eoi_vec[i]` is 1 exactly when entry i has state 0, hardware bit 0 and EOI-request bit 1.
- R4: Delivery considers only entries whose state is exactly 1. It reports the lowest full priority and breaks ties by the lowest index. `deliv_valid` is 0 when no entry is pending.
- R5: A completion ID matches an entry only when the virtual IDs are equal and state bit 1 is set (state 2 or 3). When several entries match, the lowest index is reported.
- R6: A completion that hits changes the matched entry's state from 2 to 0, or from 3 to 1, at the next edge, and leaves its other fields unchanged. A register write to the same index in the same cycle takes precedence.
- R7: A completion that misses increments `eoi_count` by one, wrapping modulo 2^CNT_W, and modifies no entry.
- R8: Re-lookup matches an entry whose virtual ID is equal and whose state is non-zero, and reports the lowest such index. `rl_err` is 1 when `rl_req` is 1 and nothing matches.
- R9: After reset every register reads 0, `eoi_count` is 0 and every entry is marked empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index to write |
| wr_data | input | 32 | Register word to write |
| rd_idx | input | IDX_W | Register index to read |
| rd_data | output | 32 | Selected register word |
| cmp_en | input | 1 | End-of-interrupt or deactivate write strobe |
| cmp_id | input | 10 | Virtual ID carried by the completion |
| cmp_hit | output | 1 | Completion matches an active entry |
| cmp_idx | output | IDX_W | Index of the matching entry |
| rl_req | input | 1 | Re-lookup request |
| rl_id | input | 10 | Virtual ID to re-locate |
| rl_hit | output | 1 | In-use entry found |
| rl_idx | output | IDX_W | Index of the found entry |
| rl_err | output | 1 | Request made and no in-use entry found |
| empty_vec | output | NUM_LR | Per-entry free status |
| eoi_vec | output | NUM_LR | Per-entry EOI maintenance status |
| deliv_valid | output | 1 | A pending entry is selected |
| deliv_idx | output | IDX_W | Index of the selected entry |
| deliv_vid | output | 10 | Virtual ID of the selected entry |
| deliv_prio | output | 8 | Full priority of the selected entry |
| eoi_count | output | CNT_W | Count of completions that missed |

## Verification
The assertions assume that `wr_idx`, `rd_idx` and the state field always carry defined values, and that the interrupt IDs stay stable within a cycle. The property on R6 also assumes that the write and the retirement of the same index in one cycle are resolved in favour of the write. The stimulus drives every input from a seeded generator at the falling edge only. It draws virtual IDs from a small pool so that duplicate IDs, matches of any state and write/completion collisions on one index all occur, and it never leaves an input undefined after reset.

// File: rtl/vlr_pkg.sv
`timescale 1ns/1ps
package vlr_pkg;
  localparam int VID_W  = 10;
  localparam int PRI_W  = 5;
  localparam int FPRI_W = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_INV     = 2'd0,
    ST_PEND    = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACTPEND = 2'd3
  } vlr_state_e;

  // packed MSB first: state[31:30] hw[29] grp[28] prio[27:23] eoi_req[22]
  // cpu[21:19] pid[18:10] vid[9:0]
  typedef struct packed {
    vlr_state_e       state;
    logic             hw;
    logic             grp;
    logic [PRI_W-1:0] prio;
    logic             eoi_req;
    logic [2:0]       cpu;
    logic [8:0]       pid;
    logic [VID_W-1:0] vid;
  } vlr_entry_t;

  function automatic logic [FPRI_W-1:0] full_prio(input vlr_entry_t e);
    return {e.prio, 3'b000};
  endfunction

  function automatic logic is_free(input vlr_entry_t e);
    return (e.state == ST_INV) && (e.hw || !e.eoi_req);
  endfunction

  function automatic logic needs_eoi(input vlr_entry_t e);
    return (e.state == ST_INV) && !e.hw && e.eoi_req;
  endfunction

  function automatic logic is_active(input vlr_entry_t e);
    return e.state[1];
  endfunction

  function automatic logic in_use(input vlr_entry_t e);
    return e.state != ST_INV;
  endfunction

  function automatic vlr_state_e retire(input vlr_state_e s);
    return vlr_state_e'({1'b0, s[0]});
  endfunction
endpackage

// File: rtl/vlr_entry_bank.sv
`timescale 1ns/1ps
module vlr_entry_bank
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  vlr_entry_t              wr_data,
  input  logic                    ret_en,
  input  logic [IDX_W-1:0]        ret_idx,
  output vlr_entry_t [NUM_LR-1:0] ents
);
  genvar g;
  generate
    for (g = 0; g < NUM_LR; g++) begin : g_ent
      logic wr_sel, ret_sel;
      assign wr_sel  = wr_en  && (wr_idx  == IDX_W'(g));
      assign ret_sel = ret_en && (ret_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ents[g] <= '0;
        else if (wr_sel)  ents[g] <= wr_data;
        else if (ret_sel) ents[g].state <= retire(ents[g].state);
      end
    end
  endgenerate

  // R6: a retirement without a colliding write clears only the active bit
  a_r6_retire_state: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en && !(wr_en && wr_idx == ret_idx)
      |=> ents[$past(ret_idx)].state == retire($past(ents[ret_idx].state)));
  // R6: other fields untouched by a retirement
  a_r6_retire_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en && !(wr_en && wr_idx == ret_idx)
      |=> ents[$past(ret_idx)].vid == $past(ents[ret_idx].vid));
endmodule

// File: rtl/vlr_status_decode.sv
`timescale 1ns/1ps
module vlr_status_decode
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 8
) (
  input  vlr_entry_t [NUM_LR-1:0] ents,
  output logic [NUM_LR-1:0]       empty_vec,
  output logic [NUM_LR-1:0]       eoi_vec
);
  genvar g;
  generate
    for (g = 0; g < NUM_LR; g++) begin : g_dec
      assign empty_vec[g] = is_free(ents[g]);
      assign eoi_vec[g]   = needs_eoi(ents[g]);
    end
  endgenerate

  // R2 R3: an entry is never both free and awaiting maintenance
  always_comb begin
    a_r3_disjoint: assert ((empty_vec & eoi_vec) == '0 || $isunknown(ents));
  end
endmodule

// File: rtl/vlr_match_scan.sv
`timescale 1ns/1ps
module vlr_match_scan
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 8,
  parameter bit NEED_ACTIVE = 1'b1,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  vlr_entry_t [NUM_LR-1:0] ents,
  input  logic [VID_W-1:0]        id,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [NUM_LR-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NUM_LR; g++) begin : g_cand
      if (NEED_ACTIVE) begin : g_act
        assign cand[g] = (ents[g].vid == id) && is_active(ents[g]);
      end else begin : g_use
        assign cand[g] = (ents[g].vid == id) && in_use(ents[g]);
      end
    end
  endgenerate

  // first match wins: scan downward so the lowest index is written last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vlr_prio_select.sv
`timescale 1ns/1ps
module vlr_prio_select
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  vlr_entry_t [NUM_LR-1:0] ents,
  output logic                    valid,
  output logic [IDX_W-1:0]        idx,
  output logic [VID_W-1:0]        vid,
  output logic [FPRI_W-1:0]       prio
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    prio  = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (ents[i].state == ST_PEND && (!valid || full_prio(ents[i]) < prio)) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        prio  = full_prio(ents[i]);
      end
    end
    vid = valid ? ents[idx].vid : '0;
    if (!valid) prio = '0;
  end
endmodule

// File: rtl/vlr_lookup_unit.sv
`timescale 1ns/1ps
module vlr_lookup_unit
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 8,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                cmp_en,
  input  logic [VID_W-1:0]    cmp_id,
  output logic                cmp_hit,
  output logic [IDX_W-1:0]    cmp_idx,
  input  logic                rl_req,
  input  logic [VID_W-1:0]    rl_id,
  output logic                rl_hit,
  output logic [IDX_W-1:0]    rl_idx,
  output logic                rl_err,
  output logic [NUM_LR-1:0]   empty_vec,
  output logic [NUM_LR-1:0]   eoi_vec,
  output logic                deliv_valid,
  output logic [IDX_W-1:0]    deliv_idx,
  output logic [VID_W-1:0]    deliv_vid,
  output logic [FPRI_W-1:0]   deliv_prio,
  output logic [CNT_W-1:0]    eoi_count
);
  vlr_entry_t [NUM_LR-1:0] ents;

  // named internal events for the assertions
  logic cmp_retire, cmp_miss;
  assign cmp_retire = cmp_en && cmp_hit;
  assign cmp_miss   = cmp_en && !cmp_hit;

  vlr_entry_bank #(.NUM_LR(NUM_LR)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(vlr_entry_t'(wr_data)),
    .ret_en(cmp_retire), .ret_idx(cmp_idx),
    .ents(ents)
  );

  vlr_status_decode #(.NUM_LR(NUM_LR)) u_dec (
    .ents(ents), .empty_vec(empty_vec), .eoi_vec(eoi_vec)
  );

  vlr_match_scan #(.NUM_LR(NUM_LR), .NEED_ACTIVE(1'b1)) u_cmp_scan (
    .ents(ents), .id(cmp_id), .hit(cmp_hit), .idx(cmp_idx)
  );

  vlr_match_scan #(.NUM_LR(NUM_LR), .NEED_ACTIVE(1'b0)) u_rl_scan (
    .ents(ents), .id(rl_id), .hit(rl_hit), .idx(rl_idx)
  );

  vlr_prio_select #(.NUM_LR(NUM_LR)) u_sel (
    .ents(ents), .valid(deliv_valid), .idx(deliv_idx),
    .vid(deliv_vid), .prio(deliv_prio)
  );

  assign rl_err  = rl_req && !rl_hit;
  assign rd_data = WORD_W'(ents[rd_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eoi_count <= '0;
    else if (cmp_miss) eoi_count <= eoi_count + 1'b1;
  end

  // R7: a miss advances the counter by exactly one
  a_r7_miss_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_miss |=> eoi_count == $past(eoi_count) + 1'b1);
  // R7: a miss with no write leaves the register bank unchanged
  a_r7_no_modify: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_miss && !wr_en |=> ents == $past(ents));
  // R4: the delivered entry is exactly pending
  a_r4_deliv_pending: assert property (@(posedge clk) disable iff (!rst_n)
    deliv_valid |-> ents[deliv_idx].state == ST_PEND);
  // R5: a completion hit points at an active entry with the same ID
  a_r5_cmp_active: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> ents[cmp_idx].state[1] && ents[cmp_idx].vid == cmp_id);
  // R8: re-lookup covers every entry that completion validation accepts
  a_r8_superset: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit && rl_id == cmp_id |-> rl_hit);
  // R8: an error is only raised on a request
  a_r8_err_req: assert property (@(posedge clk) disable iff (!rst_n)
    rl_err |-> rl_req && !rl_hit);
endmodule

// File: tb/sim_vlr_lookup_unit.sv
`timescale 1ns/1ps
module sim_vlr_lookup_unit;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [31:0] rd_data;
  logic cmp_en = 1'b0;
  logic [9:0] cmp_id = '0;
  logic cmp_hit;
  logic [IW-1:0] cmp_idx;
  logic rl_req = 1'b0;
  logic [9:0] rl_id = '0;
  logic rl_hit, rl_err;
  logic [IW-1:0] rl_idx;
  logic [N-1:0] empty_vec, eoi_vec;
  logic deliv_valid;
  logic [IW-1:0] deliv_idx;
  logic [9:0] deliv_vid;
  logic [7:0] deliv_prio;
  logic [CW-1:0] eoi_count;

  vlr_lookup_unit #(.NUM_LR(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cmp_en(cmp_en), .cmp_id(cmp_id),
    .cmp_hit(cmp_hit), .cmp_idx(cmp_idx), .rl_req(rl_req), .rl_id(rl_id),
    .rl_hit(rl_hit), .rl_idx(rl_idx), .rl_err(rl_err), .empty_vec(empty_vec),
    .eoi_vec(eoi_vec), .deliv_valid(deliv_valid), .deliv_idx(deliv_idx),
    .deliv_vid(deliv_vid), .deliv_prio(deliv_prio), .eoi_count(eoi_count)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: plain integers, one word per register
  int unsigned mw[N];
  int mcnt = 0;

  function automatic int f_state(int unsigned w); return int'((w >> 30) & 3); endfunction
  function automatic int f_vid(int unsigned w);   return int'(w & 32'h3ff); endfunction
  function automatic int f_hw(int unsigned w);    return int'((w >> 29) & 1); endfunction
  function automatic int f_eoi(int unsigned w);   return int'((w >> 22) & 1); endfunction
  function automatic int f_prio(int unsigned w);  return int'(((w >> 23) & 31) * 8); endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model for the inputs now applied
  task automatic compare();
    int e_empty = 0, e_eoi = 0;
    int best = 1000, bidx = -1;
    int chit = -1, rhit = -1;
    for (int i = 0; i < N; i++) begin
      int s = f_state(mw[i]);
      if (s == 0 && (f_hw(mw[i]) == 1 || f_eoi(mw[i]) == 0)) e_empty |= (1 << i);
      if (s == 0 && f_hw(mw[i]) == 0 && f_eoi(mw[i]) == 1) e_eoi |= (1 << i);
      if (s == 1 && f_prio(mw[i]) < best) best = f_prio(mw[i]);
    end
    for (int i = 0; i < N; i++) if (bidx < 0 && f_state(mw[i]) == 1 && f_prio(mw[i]) == best) bidx = i;
    for (int i = 0; i < N; i++) if (chit < 0 && f_vid(mw[i]) == int'(cmp_id) && f_state(mw[i]) >= 2) chit = i;
    for (int i = 0; i < N; i++) if (rhit < 0 && f_vid(mw[i]) == int'(rl_id) && f_state(mw[i]) != 0) rhit = i;
    chk(empty_vec == e_empty[N-1:0], "R2 empty_vec", empty_vec, e_empty);
    chk(eoi_vec == e_eoi[N-1:0], "R3 eoi_vec", eoi_vec, e_eoi);
    chk(deliv_valid == (bidx >= 0), "R4 deliv_valid", deliv_valid, bidx >= 0);
    if (bidx >= 0) begin
      chk(int'(deliv_idx) == bidx, "R4 deliv_idx", deliv_idx, bidx);
      chk(int'(deliv_vid) == f_vid(mw[bidx]), "R4 deliv_vid", deliv_vid, f_vid(mw[bidx]));
      chk(int'(deliv_prio) == best, "R1 deliv_prio", deliv_prio, best);
    end
    if (cmp_en) begin
      chk(cmp_hit == (chit >= 0), "R5 cmp_hit", cmp_hit, chit >= 0);
      if (chit >= 0) chk(int'(cmp_idx) == chit, "R5 cmp_idx", cmp_idx, chit);
    end
    chk(rl_hit == (rhit >= 0), "R8 rl_hit", rl_hit, rhit >= 0);
    if (rhit >= 0) chk(int'(rl_idx) == rhit, "R8 rl_idx", rl_idx, rhit);
    chk(rl_err == (rl_req && rhit < 0), "R8 rl_err", rl_err, rl_req && rhit < 0);
    chk(rd_data == mw[rd_idx], "R1 rd_data", rd_data, mw[rd_idx]);
    chk(int'(eoi_count) == mcnt, "R7 eoi_count", eoi_count, mcnt);
    // model advance for the coming edge: completion, then write wins (R6, R7)
    if (cmp_en) begin
      if (chit >= 0) mw[chit] = (mw[chit] & 32'h3fff_ffff) | (mw[chit] & 32'h4000_0000);
      else mcnt = (mcnt + 1) % (1 << CW);
    end
    if (wr_en) mw[wr_idx] = wr_data;
  endtask

  // one cycle: inputs already set at the falling edge
  task automatic cyc();
    #1;
    compare();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int st, int hw, int eoi, int pr, int vid);
    return {st[1:0], hw[0], 1'b0, pr[4:0], eoi[0], 3'd2, 9'h0a5, vid[9:0]};
  endfunction

  task automatic put(int idx, logic [31:0] w);
    wr_en = 1; wr_idx = idx[IW-1:0]; wr_data = w; cmp_en = 0; rl_req = 0;
    cyc();
    wr_en = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mw[i] = 0;
    @(negedge clk); @(negedge clk);
    // R9: reset state
    chk(eoi_count == 0, "R9 count at reset", eoi_count, 0);
    chk(empty_vec == '1, "R9 empty at reset", empty_vec, 8'hff);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      rd_idx = i[IW-1:0]; #1;
      chk(rd_data == 0, "R9 register at reset", rd_data, 0);
    end
    // R4 tie on priority, R5 duplicate active IDs, R8 re-lookup any state
    put(0, mk(1, 0, 0, 6, 7));
    put(1, mk(1, 0, 0, 3, 9));
    put(2, mk(1, 0, 0, 3, 11));
    put(3, mk(2, 0, 1, 1, 20));
    put(4, mk(3, 0, 1, 1, 20));
    put(5, mk(0, 0, 1, 0, 30));
    put(6, mk(0, 1, 1, 0, 31));
    rd_idx = 3;
    cmp_en = 1; cmp_id = 20; rl_req = 1; rl_id = 20; cyc();   // R6 hit idx3 2->0
    cmp_en = 1; cmp_id = 20; cyc();                          // R6 hit idx4 3->1
    cmp_en = 1; cmp_id = 9;  rl_id = 9; cyc();               // R7 miss on pending entry
    cmp_en = 1; cmp_id = 99; rl_id = 99; cyc();              // R7 miss, R8 error
    // R6 write wins against retirement on the same index
    put(7, mk(2, 0, 0, 2, 40));
    cmp_en = 1; cmp_id = 40; wr_en = 1; wr_idx = 7; wr_data = mk(3, 0, 0, 4, 41); cyc();
    wr_en = 0; cmp_en = 0; rd_idx = 7; cyc();
    // randomized phase, small ID pool for duplicates and collisions
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en = ($urandom % 3) == 0;
      wr_idx = IW'($urandom % N);
      wr_data = {r[31:10], 10'($urandom % 6)};
      cmp_en = ($urandom % 2) == 0;
      cmp_id = 10'($urandom % 7);
      rl_req = ($urandom % 2) == 0;
      rl_id = 10'($urandom % 7);
      rd_idx = IW'($urandom % N);
      cyc();
    end
    wr_en = 0; cmp_en = 0; rl_req = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule